// File: doc/BRIEF.md
# Accumulator Readout Formatter

This unit turns a 48-bit multiply-accumulate sum into the value a core writes to a general register. A two-bit format code picks one of three readings of the sum: fractional, signed integer or unsigned integer. The fractional reading moves the binary point, rounds the bits it drops (convergent, ties to even) and can clamp the result to a 16-bit or a 32-bit signed range. The integer readings clamp the whole 48-bit sum straight to 32 bits.

Three mode inputs steer the fractional path: a narrow (16-bit) store select, a round enable for the 32-bit case, and a saturation enable. A request is presented with `valid_in`. The formatted word is registered and appears one clock later, flagged by `valid_out`. When no request is presented, the output register keeps its last value.

Top module: `mac_readout_fmt`

## Requirements
- R1: While `rst_n` is low, `valid_out` is 0 and `result` is 0.
- R2: `valid_out` equals `valid_in` delayed by one clock. `result` loads only at a clock where `valid_in` is 1, and otherwise keeps its value.
- R3: Format code 0 (fractional) with `narrow_mode`=1 works as follows. The kept value is the sum shifted arithmetically right by 24. The dropped low 24 bits are always rounded: the kept value goes up by 1 when they exceed 0x800000, and by its own bit 0 when they equal 0x800000. `result[31:16]` is 0.
- R4: Format code 0 with `narrow_mode`=0 and `round_en`=1 works as follows. The kept value is the sum shifted arithmetically right by 8. It goes up by 1 when the low 8 bits exceed 0x80, and by its own bit 0 when they equal 0x80.
- R5: Format code 0 with `narrow_mode`=0 and `round_en`=0 keeps the sum shifted arithmetically right by 8, with no rounding.
- R6: In narrow fractional mode with `sat_en`=1, a rounded value outside the signed 16-bit range gives 0x7FFF if it is positive and 0x8000 if it is negative.
- R7: In 32-bit fractional mode with `sat_en`=1, a rounded value outside the signed 32-bit range gives 0x7FFFFFFF if it is positive and 0x80000000 if it is negative.
- R8: In fractional mode with `sat_en`=0, the result is the low 16 bits (narrow mode) or the low 32 bits of the rounded value.
- R9: Format code 1 (signed integer) returns the low 32 bits when the sum fits a signed 32-bit number. Otherwise it returns 0x7FFFFFFF for a positive sum and 0x80000000 for a negative one. The mode inputs have no effect.
- R10: Format code 2 (unsigned integer) returns the low 32 bits when bits 47:32 are all 0, and 0xFFFFFFFF otherwise. The mode inputs have no effect.
- R11: Format code 3 is reserved and gives a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Request strobe |
| acc_in | input | 48 | Accumulator sum, two's complement |
| fmt_sel | input | 2 | 0 fractional, 1 signed integer, 2 unsigned integer, 3 reserved |
| round_en | input | 1 | Enables rounding in 32-bit fractional mode |
| narrow_mode | input | 1 | Selects 16-bit fractional store |
| sat_en | input | 1 | Enables clamping in fractional mode |
| valid_out | output | 1 | Result strobe, one clock after `valid_in` |
| result | output | 32 | Formatted word |

## Verification
Rounding and saturation can act on the same request. A tie that rounds up can carry the kept value just past the largest positive number, and the clamp must then catch it. The bench sets this up with sums whose kept part is already at the 16-bit or 32-bit limit, whose kept LSB is odd and whose dropped bits are exactly one half. It runs each such sum with saturation on and off. The expected values are the clamped limit and the wrapped value, both taken from a behavioural integer model that does the rounding and the range test in its own arithmetic.

// File: rtl/mac_fmt_pkg.sv
package mac_fmt_pkg;
  typedef enum logic [1:0] {
    FMT_FRAC = 2'd0,
    FMT_SINT = 2'd1,
    FMT_UINT = 2'd2,
    FMT_RSVD = 2'd3
  } mac_fmt_e;
endpackage

// File: rtl/mac_fmt_round.sv
module mac_fmt_round #(
  parameter int ACC_W     = 48,
  parameter int WIDE_SH   = 8,
  parameter int NARROW_SH = 24
) (
  input  logic [ACC_W-1:0]      acc,
  input  logic                  narrow,
  input  logic                  round_en,
  output logic signed [ACC_W:0] rounded,
  output logic                  round_up
);
  localparam int KW = ACC_W + 1;

  // tie-to-even decision on the bits dropped by a right shift of sh
  function automatic logic tie_even_up(input logic [ACC_W-1:0] a,
                                       input int sh, input logic lsb);
    logic [ACC_W-1:0] one, rem, half;
    one  = {{(ACC_W-1){1'b0}}, 1'b1};
    rem  = a & ((one << sh) - one);
    half = one << (sh - 1);
    return (rem > half) || ((rem == half) && lsb);
  endfunction

  logic signed [KW-1:0] ext, kept;

  always_comb begin
    ext = $signed({acc[ACC_W-1], acc});
    if (narrow) begin
      kept     = ext >>> NARROW_SH;
      round_up = tie_even_up(acc, NARROW_SH, kept[0]);
    end else begin
      kept     = ext >>> WIDE_SH;
      round_up = round_en && tie_even_up(acc, WIDE_SH, kept[0]);
    end
    rounded = kept + KW'(round_up);
  end
endmodule

// File: rtl/mac_fmt_sat.sv
module mac_fmt_sat #(
  parameter int ACC_W  = 48,
  parameter int OUT_W  = 32,
  parameter int HALF_W = 16
) (
  input  logic signed [ACC_W:0] rounded,
  input  logic                  narrow,
  input  logic                  sat_en,
  output logic [OUT_W-1:0]      frac_res,
  output logic                  sat_hit
);
  localparam int KW = ACC_W + 1;

  function automatic logic fits_signed(input logic signed [KW-1:0] v, input int w);
    logic signed [KW-1:0] u;
    u = v >>> (w - 1);
    return (u == '0) || (u == '1);
  endfunction

  logic neg;
  logic [HALF_W-1:0] half_lim;
  logic [OUT_W-1:0]  full_lim;

  always_comb begin
    neg      = rounded[KW-1];
    half_lim = neg ? {1'b1, {(HALF_W-1){1'b0}}} : {1'b0, {(HALF_W-1){1'b1}}};
    full_lim = neg ? {1'b1, {(OUT_W-1){1'b0}}}  : {1'b0, {(OUT_W-1){1'b1}}};
    if (narrow) begin
      sat_hit  = sat_en && !fits_signed(rounded, HALF_W);
      frac_res = {{(OUT_W-HALF_W){1'b0}}, (sat_hit ? half_lim : rounded[HALF_W-1:0])};
    end else begin
      sat_hit  = sat_en && !fits_signed(rounded, OUT_W);
      frac_res = sat_hit ? full_lim : rounded[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/mac_fmt_int.sv
module mac_fmt_int #(
  parameter int ACC_W = 48,
  parameter int OUT_W = 32
) (
  input  logic [ACC_W-1:0] acc,
  input  logic             is_unsigned,
  output logic [OUT_W-1:0] int_res,
  output logic             clamp_hit
);
  localparam int KW = ACC_W + 1;

  function automatic logic upper_is_sign(input logic [ACC_W-1:0] a);
    logic signed [KW-1:0] u;
    u = $signed({a[ACC_W-1], a}) >>> (OUT_W - 1);
    return (u == '0) || (u == '1);
  endfunction

  always_comb begin
    if (is_unsigned) begin
      clamp_hit = (acc[ACC_W-1:OUT_W] != '0);
      int_res   = clamp_hit ? '1 : acc[OUT_W-1:0];
    end else begin
      clamp_hit = !upper_is_sign(acc);
      if (clamp_hit)
        int_res = acc[ACC_W-1] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
      else
        int_res = acc[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/mac_readout_fmt.sv
module mac_readout_fmt
  import mac_fmt_pkg::*;
#(
  parameter int ACC_W     = 48,
  parameter int OUT_W     = 32,
  parameter int HALF_W    = 16,
  parameter int WIDE_SH   = 8,
  parameter int NARROW_SH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_in,
  input  logic [ACC_W-1:0] acc_in,
  input  logic [1:0]       fmt_sel,
  input  logic             round_en,
  input  logic             narrow_mode,
  input  logic             sat_en,
  output logic             valid_out,
  output logic [OUT_W-1:0] result
);
  mac_fmt_e fmt;
  assign fmt = mac_fmt_e'(fmt_sel);

  // named internal events, observed by the bound checker
  logic                  round_up;
  logic                  frac_sat_hit;
  logic                  int_clamp_hit;
  logic signed [ACC_W:0] rounded;
  logic [OUT_W-1:0]      frac_res, int_res, next_res;

  mac_fmt_round #(.ACC_W(ACC_W), .WIDE_SH(WIDE_SH), .NARROW_SH(NARROW_SH)) u_round (
    .acc(acc_in), .narrow(narrow_mode), .round_en(round_en),
    .rounded(rounded), .round_up(round_up)
  );

  mac_fmt_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W), .HALF_W(HALF_W)) u_sat (
    .rounded(rounded), .narrow(narrow_mode), .sat_en(sat_en),
    .frac_res(frac_res), .sat_hit(frac_sat_hit)
  );

  mac_fmt_int #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_int (
    .acc(acc_in), .is_unsigned(fmt == FMT_UINT),
    .int_res(int_res), .clamp_hit(int_clamp_hit)
  );

  always_comb begin
    unique case (fmt)
      FMT_FRAC: next_res = frac_res;
      FMT_SINT,
      FMT_UINT: next_res = int_res;
      default:  next_res = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      result    <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) result <= next_res;
    end
  end
endmodule

// File: rtl/mac_readout_fmt_chk.sv
module mac_readout_fmt_chk #(
  parameter int ACC_W  = 48,
  parameter int OUT_W  = 32,
  parameter int HALF_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid_in,
  input logic [ACC_W-1:0] acc_in,
  input logic [1:0]       fmt_sel,
  input logic             round_en,
  input logic             narrow_mode,
  input logic             sat_en,
  input logic             valid_out,
  input logic [OUT_W-1:0] result,
  input logic             round_up,
  input logic             frac_sat_hit,
  input logic             int_clamp_hit
);
  localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] POS_H   = {{(OUT_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_H   = {{(OUT_W-HALF_W){1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out);
  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> $stable(result));
  // R3
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && fmt_sel == 2'd0 && narrow_mode) |=> (result[OUT_W-1:HALF_W] == '0));
  // R5
  no_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!narrow_mode && !round_en) |-> !round_up);
  // R6
  narrow_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && fmt_sel == 2'd0 && narrow_mode && sat_en && frac_sat_hit)
      |=> (result == POS_H || result == NEG_H));
  // R7
  wide_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && fmt_sel == 2'd0 && !narrow_mode && frac_sat_hit)
      |=> (result == POS_LIM || result == NEG_LIM));
  // R9
  sint_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && fmt_sel == 2'd1 && int_clamp_hit) |=> (result == POS_LIM || result == NEG_LIM));
  // R10
  uint_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && fmt_sel == 2'd2 && acc_in[ACC_W-1:OUT_W] != '0) |=> (result == '1));
  // R11
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && fmt_sel == 2'd3) |=> (result == '0));
endmodule

bind mac_readout_fmt mac_readout_fmt_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W), .HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .acc_in(acc_in), .fmt_sel(fmt_sel),
  .round_en(round_en), .narrow_mode(narrow_mode), .sat_en(sat_en),
  .valid_out(valid_out), .result(result), .round_up(round_up),
  .frac_sat_hit(frac_sat_hit), .int_clamp_hit(int_clamp_hit)
);

// File: tb/sim_mac_readout_fmt.sv
module sim_mac_readout_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [47:0] acc_in = '0;
  logic [1:0]  fmt_sel = '0;
  logic        round_en = 1'b0, narrow_mode = 1'b0, sat_en = 1'b0;
  logic        valid_out;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mac_readout_fmt u0 (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .acc_in(acc_in), .fmt_sel(fmt_sel),
    .round_en(round_en), .narrow_mode(narrow_mode), .sat_en(sat_en),
    .valid_out(valid_out), .result(result)
  );

  // behavioural model in plain integer arithmetic
  function automatic logic [31:0] model(input logic [47:0] a, input logic [1:0] f,
                                        input logic re, input logic nar, input logic sat,
                                        output string tag);
    longint v, k, rem, half;
    v = longint'($signed(a));
    case (f)
      2'd0: begin
        if (nar) begin
          k = v >>> 24; rem = v & 64'hFF_FFFF; half = 64'h80_0000;
          if (rem > half || (rem == half && k[0])) k = k + 1;
          if (sat && (k > 32767 || k < -32768)) begin
            tag = "R6"; return (k < 0) ? 32'h8000 : 32'h7FFF;
          end
          tag = sat ? "R3" : "R8";
          return {16'h0, k[15:0]};
        end
        k = v >>> 8; rem = v & 64'hFF; half = 64'h80;
        if (re && (rem > half || (rem == half && k[0]))) k = k + 1;
        if (sat && (k > 64'sh7FFF_FFFF || k < -64'sh8000_0000)) begin
          tag = "R7"; return (k < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
        end
        tag = !sat ? "R8" : (re ? "R4" : "R5");
        return k[31:0];
      end
      2'd1: begin
        tag = "R9";
        if (v > 64'sh7FFF_FFFF) return 32'h7FFF_FFFF;
        if (v < -64'sh8000_0000) return 32'h8000_0000;
        return v[31:0];
      end
      2'd2: begin
        tag = "R10";
        return (a[47:32] == 16'h0) ? a[31:0] : 32'hFFFF_FFFF;
      end
      default: begin tag = "R11"; return 32'h0; end
    endcase
  endfunction

  logic        m_valid = 1'b0;
  logic [31:0] m_res = '0;
  string       m_tag = "R1";

  // compare every clock at the falling edge, then advance the model
  always @(negedge clk) begin
    if (!rst_n) begin
      m_valid = 1'b0; m_res = '0; m_tag = "R1";
    end else begin
      checks++;
      if (valid_out !== m_valid || result !== m_res) begin
        errors++;
        $display("FAIL %s: valid_out=%0b result=%08h expected valid_out=%0b result=%08h",
                 m_tag, valid_out, result, m_valid, m_res);
      end
      m_valid = valid_in;
      if (valid_in) m_res = model(acc_in, fmt_sel, round_en, narrow_mode, sat_en, m_tag);
      else m_tag = "R2";
    end
  end

  task automatic drive(input logic v, input logic [47:0] a, input logic [1:0] f,
                       input logic re, input logic nar, input logic sat);
    @(posedge clk); #2;
    valid_in = v; acc_in = a; fmt_sel = f; round_en = re; narrow_mode = nar; sat_en = sat;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    checks++; // R1 reset state
    if (valid_out !== 1'b0 || result !== 32'h0) begin
      errors++;
      $display("FAIL R1: valid_out=%0b result=%08h expected 0 00000000", valid_out, result);
    end
    @(posedge clk); #2 rst_n = 1'b1;

    // R4 ties to even, above and below half
    drive(1, 48'h0000_0000_0180, 0, 1, 0, 0);
    drive(1, 48'h0000_0000_0280, 0, 1, 0, 0);
    drive(1, 48'h0000_0000_0281, 0, 1, 0, 0);
    drive(1, 48'h0000_0000_017F, 0, 1, 0, 1);
    drive(1, 48'hFFFF_FFFF_FE80, 0, 1, 0, 1);
    // R5 truncation
    drive(1, 48'h0000_0000_01FF, 0, 0, 0, 1);
    // R2 idle cycles hold the result
    drive(0, 48'h1234_5678_9ABC, 1, 0, 0, 0);
    drive(0, 48'h0, 2, 1, 1, 1);
    // R7 / R8 rounding carry into the clamp, with and without saturation
    drive(1, 48'h007F_FFFF_FF80, 0, 1, 0, 1);
    drive(1, 48'h007F_FFFF_FF80, 0, 1, 0, 0);
    drive(1, 48'hFF7F_FFFF_FF00, 0, 1, 0, 1);
    // R3 / R6 narrow path
    drive(1, 48'h0000_0180_0000, 0, 0, 1, 0);
    drive(1, 48'h0000_0280_0000, 0, 0, 1, 1);
    drive(1, 48'h007F_FF80_0000, 0, 0, 1, 1);
    drive(1, 48'h007F_FF80_0000, 0, 0, 1, 0);
    drive(1, 48'hFF00_0000_0000, 0, 1, 1, 1);
    // R9 signed integer
    drive(1, 48'h0000_8000_0000, 1, 1, 1, 1);
    drive(1, 48'hFFFF_7FFF_FFFF, 1, 0, 0, 0);
    drive(1, 48'hFFFF_8000_0000, 1, 1, 0, 1);
    // R10 unsigned integer
    drive(1, 48'h0001_0000_0000, 2, 0, 1, 0);
    drive(1, 48'h0000_DEAD_BEEF, 2, 1, 0, 1);
    // R11 reserved code
    drive(1, 48'h0000_1234_5678, 3, 1, 0, 1);
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [47:0] a;
      a = {$urandom, $urandom} ;
      if (i % 4 == 0) a[23:0] = 24'h80_0000;
      if (i % 5 == 0) a[7:0] = 8'h80;
      drive(($urandom % 4) != 0, a, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    drive(0, 48'h0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule